// File: doc/BRIEF.md
# Pointer Motion Packet Encoder with Byte Queue

This block turns one pointer-device event into a fixed five-byte packet and stores those bytes in a byte queue. A receive channel drains the queue one byte at a time. An event carries signed X and Y motion and the state of three buttons. The encoder builds the packet in this order:

1. A sync byte that carries the button states.
2. The clamped X motion.
3. The clamped and negated Y motion.
4. A zero byte.
5. A second zero byte.

The encoder pushes the five bytes on consecutive cycles. While it does so it refuses any further event.

The queue holds up to 256 bytes. When it is full, any further pushed byte is silently discarded. A flush empties the queue in one cycle. A pop of an empty queue returns zero. An "available" flag is high whenever at least one byte is queued, so the consumer can keep reading until the flag drops.

The encoder is a state machine with six states:

- `ST_IDLE`: waits for an event.
- `ST_SYNC`: pushes the sync byte.
- `ST_XMOT`: pushes the X byte.
- `ST_YMOT`: pushes the Y byte.
- `ST_PAD0`: pushes the first zero byte.
- `ST_PAD1`: pushes the second zero byte.

It has these transitions:

- `ST_IDLE` to `ST_SYNC` when `evt_valid` is high.
- `ST_SYNC` to `ST_XMOT`, `ST_XMOT` to `ST_YMOT`, `ST_YMOT` to `ST_PAD0` and `ST_PAD0` to `ST_PAD1`, each unconditional.
- `ST_PAD1` back to `ST_IDLE`, also unconditional.

Top module: `mouse_pkt_queue`

## Requirements
- R1: Byte 1 is 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared when the middle button is pressed and bit 0 cleared when the right button is pressed; the button inputs are active-high.
- R2: Byte 2 is the X motion (12-bit two's complement) clamped to the range -127..+127 and sent as 8-bit two's complement: values above 127 give 0x7F, values below -127 give 0x81.
- R3: Byte 3 is the negated Y motion, clamped the same way (Y = -128 gives 0x7F, Y = +128 gives 0x81, Y = -2048 gives 0x7F).
- R4: Bytes 4 and 5 are always 0x00. The encoder pushes the five bytes on the five cycles that follow the accepting clock edge, in the order byte 1 to byte 5.
- R5: An event is accepted only when `evt_ready` is high. `evt_ready` stays low from the accepting edge until the last byte has been pushed, and an event presented during that time adds no bytes to the queue.
- R6: The queue returns bytes in first-in first-out order and holds up to 256 bytes.
- R7: A byte pushed while the queue holds 256 bytes is discarded, and the queued contents are unchanged.
- R8: Popping an empty queue returns 0x00 on `pop_data` and changes no state.
- R9: `byte_avail` is high exactly when the queue is non-empty, and it stays high after a pop that leaves bytes behind.
- R10: A one-cycle `flush` empties the queue. In the same cycle, flush takes priority over a push and over a pop, and the encoder's later pushes are queued normally.
- R11: After reset the queue is empty, `byte_avail` is low, `pop_data` is 0x00 and `evt_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event present |
| evt_dx | input | 12 | Signed X motion |
| evt_dy | input | 12 | Signed Y motion |
| btn_left | input | 1 | Left button pressed |
| btn_middle | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| evt_ready | output | 1 | Encoder idle, able to accept an event |
| flush | input | 1 | Empty the queue |
| pop | input | 1 | Remove the head byte |
| pop_data | output | 8 | Head byte, or 0x00 when the queue is empty |
| byte_avail | output | 1 | Queue is non-empty |

## Verification
The ports show a wrong internal state in the following ways:

- **Bad state sequencing.** A stuck or skipped state shows up as a wrong byte count or wrong byte order. This appears on the very next drain of the queue, at most five pops after the event.
- **Bad count after a saturating or flushed operation.** The failure surfaces when the queue is drained and emptied. A miscounted full queue either hands back a byte that should have been dropped or drops `byte_avail` early. A stale count after a flush leaves `byte_avail` high one cycle later.
- **Bad saturation or negation.** The failure shows in the second or third byte of the next packet popped.

// File: rtl/mpk_pkg.sv
package mpk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_XMOT,
        ST_YMOT,
        ST_PAD0,
        ST_PAD1
    } enc_state_e;

    localparam logic [7:0] SYNC_BASE = 8'h87;
endpackage

// File: rtl/mpk_encoder.sv
module mpk_encoder
    import mpk_pkg::*;
#(
    parameter int MW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic [MW-1:0] evt_dx,
    input  logic [MW-1:0] evt_dy,
    input  logic          btn_l,
    input  logic          btn_m,
    input  logic          btn_r,
    output logic          evt_ready,
    output logic          push,
    output logic [7:0]    push_byte
);
    localparam int EW = MW + 1;
    localparam logic signed [EW-1:0] POS_LIM = EW'(127);
    localparam logic signed [EW-1:0] NEG_LIM = -POS_LIM;

    enc_state_e state_q, state_d;
    logic [7:0] sync_q, x_q, y_q;
    logic signed [EW-1:0] x_ext, y_neg;
    logic [7:0] x_sat, y_sat;
    logic accept;

    assign accept = evt_valid && (state_q == ST_IDLE);

    always_comb begin
        x_ext = EW'($signed(evt_dx));
        y_neg = -EW'($signed(evt_dy));
        if (x_ext > POS_LIM)      x_sat = 8'h7F;
        else if (x_ext < NEG_LIM) x_sat = 8'h81;
        else                      x_sat = x_ext[7:0];
        if (y_neg > POS_LIM)      y_sat = 8'h7F;
        else if (y_neg < NEG_LIM) y_sat = 8'h81;
        else                      y_sat = y_neg[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= SYNC_BASE;
            x_q    <= '0;
            y_q    <= '0;
        end else if (accept) begin
            sync_q <= SYNC_BASE & ~{5'b0, btn_l, btn_m, btn_r};
            x_q    <= x_sat;
            y_q    <= y_sat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (evt_valid) state_d = ST_SYNC;
            ST_SYNC: state_d = ST_XMOT;
            ST_XMOT: state_d = ST_YMOT;
            ST_YMOT: state_d = ST_PAD0;
            ST_PAD0: state_d = ST_PAD1;
            ST_PAD1: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        evt_ready = 1'b0;
        push      = 1'b1;
        push_byte = 8'h00;
        unique case (state_q)
            ST_IDLE: begin
                evt_ready = 1'b1;
                push      = 1'b0;
            end
            ST_SYNC: push_byte = sync_q;
            ST_XMOT: push_byte = x_q;
            ST_YMOT: push_byte = y_q;
            ST_PAD0: push_byte = 8'h00;
            ST_PAD1: push_byte = 8'h00;
            default: push = 1'b0;
        endcase
    end

    // R5
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready) |=> (!evt_ready && push));

    // R4
    tail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAD1) |=> (evt_ready && !push));
endmodule

// File: rtl/mpk_byte_fifo.sv
module mpk_byte_fifo #(
    parameter int DEPTH = 256,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          not_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic do_wr, do_rd;

    assign do_wr     = wr_en && (count != FULL_CNT) && !flush;
    assign do_rd     = rd_en && (count != '0) && !flush;
    assign not_empty = (count != '0);
    assign rd_data   = not_empty ? mem[rptr] : '0;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
            if (do_wr && !do_rd)      count <= count + 1'b1;
            else if (do_rd && !do_wr) count <= count - 1'b1;
        end
    end

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && wr_en && !rd_en && !flush) |=>
            (count == FULL_CNT && $stable(wptr)));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && rd_en && !wr_en && !flush) |=>
            (!not_empty && $stable(rptr)));

    // R9
    avail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && count > CW'(1) && !flush) |=> not_empty);

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !not_empty);
endmodule

// File: rtl/mouse_pkt_queue.sv
module mouse_pkt_queue #(
    parameter int MW    = 12,
    parameter int DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic [MW-1:0] evt_dx,
    input  logic [MW-1:0] evt_dy,
    input  logic          btn_left,
    input  logic          btn_middle,
    input  logic          btn_right,
    output logic          evt_ready,
    input  logic          flush,
    input  logic          pop,
    output logic [7:0]    pop_data,
    output logic          byte_avail
);
    logic       enc_push;
    logic [7:0] enc_byte;

    mpk_encoder #(.MW(MW)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_dx    (evt_dx),
        .evt_dy    (evt_dy),
        .btn_l     (btn_left),
        .btn_m     (btn_middle),
        .btn_r     (btn_right),
        .evt_ready (evt_ready),
        .push      (enc_push),
        .push_byte (enc_byte)
    );

    mpk_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (enc_push),
        .wr_data   (enc_byte),
        .rd_en     (pop),
        .rd_data   (pop_data),
        .not_empty (byte_avail)
    );
endmodule

// File: tb/mouse_pkt_queue_tb.sv
module mouse_pkt_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {dx, dy, buttons {L,M,R}, expected bytes 1..3}
    localparam logic [50:0] VEC [NVEC] = '{
        {12'h000, 12'h000, 3'b000, 24'h870000},
        {12'h005, 12'h003, 3'b100, 24'h8305FD},
        {12'h0C8, 12'hED4, 3'b011, 24'h847F7F},
        {12'hF80, 12'h080, 3'b111, 24'h808181},
        {12'h07F, 12'hF81, 3'b001, 24'h867F7F},
        {12'hF81, 12'h07F, 3'b010, 24'h858181},
        {12'h800, 12'h800, 3'b100, 24'h83817F},
        {12'hFFF, 12'h001, 3'b000, 24'h87FFFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_valid = 1'b0;
    logic [11:0] evt_dx = '0, evt_dy = '0;
    logic btn_left = 1'b0, btn_middle = 1'b0, btn_right = 1'b0;
    logic evt_ready, flush = 1'b0, pop = 1'b0, byte_avail;
    logic [7:0] pop_data;
    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mouse_pkt_queue u_dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_dx(evt_dx),
        .evt_dy(evt_dy), .btn_left(btn_left), .btn_middle(btn_middle),
        .btn_right(btn_right), .evt_ready(evt_ready), .flush(flush),
        .pop(pop), .pop_data(pop_data), .byte_avail(byte_avail)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive at a falling edge; returns after the last byte is queued.
    task automatic send(input logic [11:0] dx, input logic [11:0] dy, input logic [2:0] b);
        evt_dx = dx; evt_dy = dy;
        {btn_left, btn_middle, btn_right} = b;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic pop_expect(input string req, input logic [7:0] exp);
        check(req, {7'b0, byte_avail}, 8'h01);
        check(req, pop_data, exp);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 ready", {7'b0, evt_ready}, 8'h01);
        check("R11 avail", {7'b0, byte_avail}, 8'h00);
        check("R11 data", pop_data, 8'h00);

        // R8 pop on empty, then confirm pointers undisturbed
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        check("R8 empty data", pop_data, 8'h00);
        check("R8 empty avail", {7'b0, byte_avail}, 8'h00);

        // R1 R2 R3 R4 table walk
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][50:39], VEC[i][38:27], VEC[i][26:24]);
            check("R5 ready after packet", {7'b0, evt_ready}, 8'h01);
            pop_expect("R1 sync", VEC[i][23:16]);
            pop_expect("R2 x", VEC[i][15:8]);
            pop_expect("R3 y", VEC[i][7:0]);
            pop_expect("R4 pad0", 8'h00);
            pop_expect("R9 avail with one left", 8'h00);
            check("R4 five bytes only", {7'b0, byte_avail}, 8'h00);
        end

        // R5 event during busy is ignored
        evt_dx = 12'h010; evt_dy = 12'h000; {btn_left, btn_middle, btn_right} = 3'b000;
        evt_valid = 1'b1;
        @(negedge clk);
        check("R5 busy", {7'b0, evt_ready}, 8'h00);
        evt_dx = 12'h020; {btn_left, btn_middle, btn_right} = 3'b111;
        repeat (4) @(negedge clk);
        evt_valid = 1'b0;
        @(negedge clk);
        check("R5 idle again", {7'b0, evt_ready}, 8'h01);
        pop_expect("R5 sync", 8'h87);
        pop_expect("R5 x", 8'h10);
        pop_expect("R5 y", 8'h00);
        pop_expect("R5 pad", 8'h00);
        pop_expect("R5 pad", 8'h00);
        check("R5 no extra bytes", {7'b0, byte_avail}, 8'h00);

        // R10 flush while the encoder keeps pushing
        evt_dx = 12'h033; evt_dy = 12'h000; {btn_left, btn_middle, btn_right} = 3'b000;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (2) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check("R10 flushed mid packet", {7'b0, byte_avail}, 8'h00);
        repeat (2) @(negedge clk);
        pop_expect("R10 pad after flush", 8'h00);
        pop_expect("R10 pad after flush", 8'h00);
        check("R10 empty", {7'b0, byte_avail}, 8'h00);

        // R6 R7 fill past capacity: 52 packets, 260 bytes offered
        for (int p = 0; p < 52; p++) send(12'(p), 12'h000, 3'b000);
        for (int n = 0; n < 256; n++) begin
            logic [7:0] e;
            case (n % 5)
                0: e = 8'h87;
                1: e = 8'(n / 5);
                default: e = 8'h00;
            endcase
            pop_expect((n == 255) ? "R7 last kept" : "R6 order", e);
        end
        check("R7 drop on full", {7'b0, byte_avail}, 8'h00);
        check("R8 empty after drain", pop_data, 8'h00);

        // R10 flush of a full packet
        send(12'h001, 12'h001, 3'b000);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check("R10 flush whole", {7'b0, byte_avail}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule